// File: doc/BRIEF.md
# Two-Channel Slot Serializer and Deserializer

This block carries the data paths of a two-channel serial audio port. On transmit it takes words from a transmit FIFO and shifts them out on a serial data pin. On receive it collects bits from a serial data pin and assembles them into words for a receive FIFO. Each direction has two channels. Each channel is described by a 16-bit half of a 32-bit configuration word: a start position counted in bit clocks from frame start, a sample width of 8 to 32 bits, and an enable. The same mechanism places samples for I2S, left- or right-justified and DSP-style frames. For I2S and DSP-A layouts the start position already includes the one-bit data delay. For right-justified data it includes the slot width minus the data length.

A separate frame sync generator supplies a one-cycle bit strobe and the frame position that is current on that strobe. A packed mode carries two 16-bit samples in one 32-bit FIFO word, and it can be set separately for each direction. The receive side can sign-extend samples narrower than 32 bits. The FIFOs themselves are outside this block: the transmit FIFO is show-ahead and is popped in the same cycle, and the receive FIFO takes one word per push strobe.

Top module: `slot_serdes`

## Requirements
- R1: In each configuration word, channel 1 uses bits 31:16 and channel 2 uses bits 15:0. Within a half, bits 3:0 are the width code, bits 13:4 the start position, bit 14 the enable and bit 15 the width extension.
- R2: The channel width is the width code plus 8, plus a further 16 when the extension bit is set. A result above 32 is treated as 32.
- R3: On a bit strobe where the frame position equals an enabled transmit channel's start, sd_out takes the sample's MSB at that clock edge. Each following strobe presents the next lower bit until all width bits have been sent. sd_out changes only on bit strobes.
- R4: sd_out is 0 on every strobe outside an enabled channel's window. A disabled channel never pops the transmit FIFO.
- R5: In unpacked mode each enabled transmit channel start pops one FIFO word in the same cycle. If the FIFO is empty, tx_underrun pulses in that cycle instead of tx_pop, and the channel sends zeros.
- R6: In transmit packed mode only a channel 1 start pops the FIFO. Channel 1 sends bits 15:0 of that word and channel 2 later sends bits 31:16.
- R7: A receive channel samples sd_in MSB first on the strobes of its window. One cycle after the strobe that carries its last bit, rx_push pulses for one cycle with the sample right-aligned in rx_data.
- R8: With rx_sext set, the bits of rx_data above the channel width copy the sample's top bit. With rx_sext clear they are 0.
- R9: In receive packed mode only channel 2 completion pushes. The pushed word holds channel 1's sample in bits 15:0 and channel 2's sample in bits 31:16.
- R10: During and right after reset, sd_out, rx_push, tx_pop and tx_underrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| frame_pos | input | 10 | Bit position within the frame, valid on bit_tick |
| tx_cfg | input | 32 | Transmit channel configuration |
| rx_cfg | input | 32 | Receive channel configuration |
| tx_pack | input | 1 | Transmit packed 16-bit mode |
| rx_pack | input | 1 | Receive packed 16-bit mode |
| rx_sext | input | 1 | Sign-extend received samples |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Pop the transmit FIFO this cycle |
| tx_underrun | output | 1 | Channel started with the transmit FIFO empty |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| rx_data | output | 32 | Word for the receive FIFO |
| rx_push | output | 1 | Push rx_data into the receive FIFO |

## Verification
A corrupted bit index or shift register in the transmit path shows on sd_out at the next bit strobe. A wrong word source shows at the first bit of the next channel window. A stale remaining-bit count or width on the receive side moves rx_push away from the cycle after the last bit, or corrupts rx_data, within one sample. Packed-mode hold registers only show at the other channel's window, up to half a frame later. The bench therefore compares sd_out, tx_pop, tx_underrun and rx_push against the model on every clock, and rx_data on every push.

// File: rtl/slot_serdes_pkg.sv
package slot_serdes_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = 10;
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CODE_W = 4;
  localparam int MIN_W  = 8;
  localparam int EXT_W  = 16;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] width;
    logic [POS_W-1:0] start;
  } chan_cfg_t;
endpackage

// File: rtl/slot_cfg_dec.sv
module slot_cfg_dec
  import slot_serdes_pkg::*;
(
  input  logic [HALF_W-1:0] half,
  output chan_cfg_t         cfg
);
  logic [CNT_W-1:0] raw_w;

  always_comb begin
    raw_w = CNT_W'(half[CODE_W-1:0]) + CNT_W'(MIN_W)
          + (half[HALF_W-1] ? CNT_W'(EXT_W) : '0);
    cfg.width = (raw_w > CNT_W'(WORD_W)) ? CNT_W'(WORD_W) : raw_w;
    cfg.start = half[CODE_W +: POS_W];
    cfg.en    = half[HALF_W-2];
  end
endmodule

// File: rtl/slot_tx.sv
module slot_tx
  import slot_serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [POS_W-1:0]  frame_pos,
  input  chan_cfg_t         cfg_a,
  input  chan_cfg_t         cfg_b,
  input  logic              pack,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              underrun,
  output logic              sd_out
);
  logic              hit_a, hit_b, want;
  logic [WORD_W-1:0] src, load_word;
  logic [CNT_W-1:0]  load_w, top_bit;
  logic              busy_q, busy_d, sd_q, sd_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [HALF_W-1:0] hold_q, hold_d;

  always_comb begin
    hit_a    = bit_tick && cfg_a.en && (frame_pos == cfg_a.start);
    hit_b    = bit_tick && cfg_b.en && (frame_pos == cfg_b.start) && !hit_a;
    want     = hit_a || (hit_b && !pack);
    fifo_pop = want && !fifo_empty;
    underrun = want && fifo_empty;
    src      = fifo_empty ? '0 : fifo_data;
    load_w   = hit_a ? cfg_a.width : cfg_b.width;
    top_bit  = load_w - CNT_W'(1);
    if (!pack)      load_word = src;
    else if (hit_a) load_word = {{HALF_W{1'b0}}, src[HALF_W-1:0]};
    else            load_word = {{HALF_W{1'b0}}, hold_q};
  end

  always_comb begin
    busy_d = busy_q;
    sd_d   = sd_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    hold_d = hold_q;
    if (bit_tick) begin
      if (hit_a || hit_b) begin
        sd_d   = load_word[top_bit[IDX_W-1:0]];
        idx_d  = IDX_W'(load_w - CNT_W'(2));
        busy_d = 1'b1;
        sh_d   = load_word;
        if (hit_a && pack) hold_d = src[WORD_W-1:HALF_W];
      end else if (busy_q) begin
        sd_d   = sh_q[idx_q];
        busy_d = (idx_q != '0);
        idx_d  = idx_q - IDX_W'(1);
      end else begin
        sd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
    end else begin
      busy_q <= busy_d;
      sd_q   <= sd_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      hold_q <= hold_d;
    end
  end

  assign sd_out = sd_q;

  AST_SD_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(sd_out)); // R3
  AST_POP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_pop && underrun)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !busy_q && !hit_a && !hit_b) |=> !sd_out); // R4
endmodule

// File: rtl/slot_rx.sv
module slot_rx
  import slot_serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [POS_W-1:0]  frame_pos,
  input  chan_cfg_t         cfg_a,
  input  chan_cfg_t         cfg_b,
  input  logic              pack,
  input  logic              sext,
  input  logic              sd_in,
  output logic              push,
  output logic [WORD_W-1:0] data
);
  logic              hit_a, hit_b, sgn;
  logic [WORD_W-1:0] word_raw, word_ext;
  logic [CNT_W-1:0]  msb_w;
  logic              busy_q, busy_d, ch_q, ch_d, push_q, push_d;
  logic [CNT_W-1:0]  rem_q, rem_d, wq_q, wq_d;
  logic [WORD_W-1:0] acc_q, acc_d, data_q, data_d;
  logic [HALF_W-1:0] hold_q, hold_d;

  always_comb begin
    hit_a    = bit_tick && cfg_a.en && (frame_pos == cfg_a.start);
    hit_b    = bit_tick && cfg_b.en && (frame_pos == cfg_b.start) && !hit_a;
    word_raw = {acc_q[WORD_W-2:0], sd_in};
    msb_w    = wq_q - CNT_W'(1);
    sgn      = word_raw[msb_w[IDX_W-1:0]];
    for (int i = 0; i < WORD_W; i++)
      word_ext[i] = (sext && (i > int'(msb_w))) ? sgn : word_raw[i];
  end

  always_comb begin
    busy_d = busy_q;
    ch_d   = ch_q;
    rem_d  = rem_q;
    wq_d   = wq_q;
    acc_d  = acc_q;
    hold_d = hold_q;
    data_d = data_q;
    push_d = 1'b0;
    if (bit_tick) begin
      if (hit_a || hit_b) begin
        acc_d  = {{(WORD_W-1){1'b0}}, sd_in};
        rem_d  = (hit_a ? cfg_a.width : cfg_b.width) - CNT_W'(1);
        wq_d   = hit_a ? cfg_a.width : cfg_b.width;
        ch_d   = hit_b;
        busy_d = 1'b1;
      end else if (busy_q) begin
        acc_d = word_raw;
        rem_d = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) begin
          busy_d = 1'b0;
          if (!pack) begin
            push_d = 1'b1;
            data_d = word_ext;
          end else if (!ch_q) begin
            hold_d = word_ext[HALF_W-1:0];
          end else begin
            push_d = 1'b1;
            data_d = {word_ext[HALF_W-1:0], hold_q};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= 1'b0;
      rem_q  <= '0;
      wq_q   <= CNT_W'(MIN_W);
      acc_q  <= '0;
      hold_q <= '0;
      data_q <= '0;
      push_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ch_q   <= ch_d;
      rem_q  <= rem_d;
      wq_q   <= wq_d;
      acc_q  <= acc_d;
      hold_q <= hold_d;
      data_q <= data_d;
      push_q <= push_d;
    end
  end

  assign push = push_q;
  assign data = data_q;

  AST_PUSH_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(bit_tick)); // R7
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push); // R7
endmodule

// File: rtl/slot_serdes.sv
module slot_serdes
  import slot_serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [POS_W-1:0]  frame_pos,
  input  logic [WORD_W-1:0] tx_cfg,
  input  logic [WORD_W-1:0] rx_cfg,
  input  logic              tx_pack,
  input  logic              rx_pack,
  input  logic              rx_sext,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              tx_underrun,
  output logic              sd_out,
  input  logic              sd_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_push
);
  localparam int NCH = 2;

  logic      rst_m, rst_s;
  chan_cfg_t tx_ch [NCH];
  chan_cfg_t rx_ch [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    slot_cfg_dec u_tx_dec (
      .half (tx_cfg[WORD_W-1-g*HALF_W -: HALF_W]),
      .cfg  (tx_ch[g])
    );
    slot_cfg_dec u_rx_dec (
      .half (rx_cfg[WORD_W-1-g*HALF_W -: HALF_W]),
      .cfg  (rx_ch[g])
    );
  end

  slot_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_s),
    .bit_tick   (bit_tick),
    .frame_pos  (frame_pos),
    .cfg_a      (tx_ch[0]),
    .cfg_b      (tx_ch[1]),
    .pack       (tx_pack),
    .fifo_data  (tx_data),
    .fifo_empty (tx_empty),
    .fifo_pop   (tx_pop),
    .underrun   (tx_underrun),
    .sd_out     (sd_out)
  );

  slot_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_s),
    .bit_tick  (bit_tick),
    .frame_pos (frame_pos),
    .cfg_a     (rx_ch[0]),
    .cfg_b     (rx_ch[1]),
    .pack      (rx_pack),
    .sext      (rx_sext),
    .sd_in     (sd_in),
    .push      (rx_push),
    .data      (rx_data)
  );
endmodule

// File: tb/slot_serdes_tb.sv
module slot_serdes_tb;
  localparam int FRAME = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_tick;
  logic [9:0]  frame_pos;
  logic [31:0] tx_cfg, rx_cfg, tx_data, rx_data;
  logic        tx_pack, rx_pack, rx_sext, tx_empty, tx_pop, tx_underrun;
  logic        sd_out, sd_in, rx_push;

  always #10 clk = ~clk;

  slot_serdes u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_pos(frame_pos),
    .tx_cfg(tx_cfg), .rx_cfg(rx_cfg), .tx_pack(tx_pack), .rx_pack(rx_pack),
    .rx_sext(rx_sext), .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .tx_underrun(tx_underrun), .sd_out(sd_out), .sd_in(sd_in),
    .rx_data(rx_data), .rx_push(rx_push)
  );

  int errors = 0, checks = 0;
  string tag;
  int fpos, cyc, divn;
  int n_pop, n_under, n_push;

  // reference model state
  bit          txq[$];
  logic [31:0] fifo[$];
  logic [15:0] m_thold, m_rhold;
  bit          rxb[$];
  bit          r_act;
  int          r_w, r_ch;
  bit          e_sd, e_push;
  logic [31:0] e_data;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // field decode per R1 / R2
  function automatic int f_w(logic [15:0] h);
    int w = int'(h[3:0]) + 8 + (h[15] ? 16 : 0);
    return (w > 32) ? 32 : w;
  endfunction
  function automatic int f_st(logic [15:0] h); return int'(h[13:4]); endfunction
  function automatic bit f_en(logic [15:0] h); return h[14]; endfunction
  function automatic logic [15:0] mk(bit en, bit ext, int st, int code);
    return {ext, en, 10'(st), 4'(code)};
  endfunction

  function automatic bit start_hit(logic [31:0] c, int ch);
    logic [15:0] h = ch == 0 ? c[31:16] : c[15:0];
    return bit_tick && f_en(h) && (int'(frame_pos) == f_st(h));
  endfunction

  task automatic model();
    bit s1, s2, r1, r2;
    logic [31:0] word, v;
    int w;
    e_push = 1'b0;
    if (!bit_tick) return;
    s1 = start_hit(tx_cfg, 0);
    s2 = start_hit(tx_cfg, 1) && !s1;
    if (s1 || s2) begin
      w = f_w(s1 ? tx_cfg[31:16] : tx_cfg[15:0]);
      word = 0;
      if (s1 || !tx_pack) word = (fifo.size() > 0) ? fifo.pop_front() : 32'h0;
      if (tx_pack) begin
        if (s1) begin m_thold = word[31:16]; word = {16'h0, word[15:0]}; end
        else word = {16'h0, m_thold};
      end
      txq.delete();
      for (int i = w - 1; i >= 0; i--) txq.push_back(word[i]);
    end
    e_sd = (txq.size() > 0) ? txq.pop_front() : 1'b0;
    r1 = start_hit(rx_cfg, 0);
    r2 = start_hit(rx_cfg, 1) && !r1;
    if (r1 || r2) begin
      rxb.delete(); rxb.push_back(sd_in);
      r_act = 1; r_ch = r2 ? 1 : 0;
      r_w = f_w(r2 ? rx_cfg[15:0] : rx_cfg[31:16]);
    end else if (r_act) begin
      rxb.push_back(sd_in);
      if (rxb.size() == r_w) begin
        r_act = 0;
        v = 0;
        foreach (rxb[i]) v = {v[30:0], rxb[i]};
        if (rx_sext && r_w < 32 && v[r_w-1]) v = v | (32'hFFFF_FFFF << r_w);
        if (!rx_pack) begin e_push = 1; e_data = v; end
        else if (r_ch == 0) m_rhold = v[15:0];
        else begin e_push = 1; e_data = {v[15:0], m_rhold}; end
      end
    end
  endtask

  task automatic cycle();
    bit want;
    @(negedge clk);
    chk(sd_out === e_sd, {tag, " R3"}, "sd_out", sd_out, e_sd);
    chk(rx_push === e_push, {tag, " R7"}, "rx_push", rx_push, e_push);
    if (e_push) chk(rx_data === e_data, {tag, " R7"}, "rx_data", rx_data, e_data);
    bit_tick  = (cyc % divn) == 0;
    frame_pos = 10'(fpos);
    tx_empty  = fifo.size() == 0;
    tx_data   = tx_empty ? $urandom : fifo[0];
    sd_in     = $urandom_range(0, 1);
    cyc++;
    #1;
    want = start_hit(tx_cfg, 0) || (start_hit(tx_cfg, 1) && !tx_pack);
    chk(tx_pop === (want && !tx_empty), {tag, " R5"}, "tx_pop", tx_pop, want && !tx_empty);
    chk(tx_underrun === (want && tx_empty), {tag, " R5"}, "tx_underrun",
        tx_underrun, want && tx_empty);
    n_pop   += int'(tx_pop);
    n_under += int'(tx_underrun);
    @(posedge clk);
    model();
    n_push += int'(e_push);
    if (bit_tick) fpos = (fpos + 1) % FRAME;
  endtask

  task automatic run(string t, logic [31:0] tc, logic [31:0] rc, bit tp, bit rp,
                     bit sx, int words, int frames, int d);
    tag = t; tx_cfg = tc; rx_cfg = rc; tx_pack = tp; rx_pack = rp; rx_sext = sx;
    fifo.delete();
    for (int i = 0; i < words; i++) fifo.push_back($urandom);
    fpos = 0; cyc = 0; divn = d; n_pop = 0; n_under = 0; n_push = 0;
    repeat (frames * FRAME * d) cycle();
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; bit_tick = 0; frame_pos = 0; tx_cfg = 0; rx_cfg = 0;
    tx_pack = 0; rx_pack = 0; rx_sext = 0; tx_data = 0; tx_empty = 1; sd_in = 0;
    e_sd = 0; e_push = 0; e_data = 0; r_act = 0; m_thold = 0; m_rhold = 0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    chk(sd_out === 1'b0, "R10", "sd_out", sd_out, 0);
    chk(rx_push === 1'b0, "R10", "rx_push", rx_push, 0);
    chk(tx_pop === 1'b0 && tx_underrun === 1'b0, "R10", "fifo strobes",
        {tx_pop, tx_underrun}, 0);
    rst_n = 1;
    divn = 1000; cyc = 1; fpos = 0; tag = "R10";
    repeat (4) cycle();

    // R1 R3: I2S-like 16-bit slots, one-bit delay
    run("R1 R3", {mk(1,0,1,8), mk(1,0,33,8)}, {mk(1,0,1,8), mk(1,0,33,8)},
        0, 0, 0, 6, 3, 1);
    chk(n_pop == 6, "R5", "pops", n_pop, 6);
    chk(n_push == 6, "R7", "pushes", n_push, 6);
    // R2: 24-bit via extension, half-rate strobe
    run("R2", {mk(1,1,0,0), mk(1,1,32,0)}, {mk(1,1,8,0), mk(1,1,40,0)},
        0, 0, 0, 4, 2, 2);
    chk(n_push == 4, "R2", "pushes", n_push, 4);
    // R2: 32-bit and clamped code 15 + extension
    run("R2", {mk(1,1,0,15), mk(1,1,32,8)}, {mk(1,1,0,15), mk(1,1,32,8)},
        0, 0, 0, 4, 2, 1);
    // R8: sign extension for 12- and 20-bit samples
    run("R8", {mk(1,0,3,4), mk(1,0,40,12)}, {mk(1,0,3,4), mk(1,0,40,12)},
        0, 0, 1, 6, 4, 1);
    // R8: same widths without extension
    run("R8", {mk(0,0,3,4), mk(0,0,40,12)}, {mk(1,0,3,4), mk(1,0,40,12)},
        0, 0, 0, 0, 2, 1);
    chk(n_under == 0 && n_pop == 0, "R4", "strobes with disabled tx", n_pop + n_under, 0);
    // R6 R9: packed 16-bit
    run("R6 R9", {mk(1,0,0,8), mk(1,0,32,8)}, {mk(1,0,0,8), mk(1,0,32,8)},
        1, 1, 0, 3, 3, 1);
    chk(n_pop == 3, "R6", "packed pops", n_pop, 3);
    chk(n_push == 3, "R9", "packed pushes", n_push, 3);
    // R5: empty FIFO underruns, zeros sent
    run("R5", {mk(1,0,5,8), mk(0,0,20,8)}, 32'h0, 0, 0, 0, 0, 2, 1);
    chk(n_under == 2, "R5", "underruns", n_under, 2);
    chk(n_push == 0, "R4", "pushes with rx disabled", n_push, 0);
    // R4: disabled channel 2 never pops
    run("R4", {mk(1,0,5,8), mk(0,0,20,8)}, 32'h0, 0, 0, 0, 4, 2, 1);
    chk(n_pop == 2, "R4", "pops with ch2 disabled", n_pop, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule